// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one memory access command into the string of column addresses that the burst visits. A controller hands over a command (read or write, with an 8-bit starting column) on a valid/ready port. The block then streams one column address per beat on a second valid/ready port. The final beat is flagged, and the read/write kind of the command travels with every beat. Two configuration pins choose the burst length (2, 4 or 8 beats) and the visiting order (sequential or interleaved). The block samples both pins when it accepts the command.

Every burst stays inside an aligned block of columns whose size equals the burst length. The column bits above the block offset never change during a burst. The offset bits walk through the block in one of two ways. In sequential order the offset counts up from the starting offset and wraps at the block edge. In interleaved order the offset on beat i is the starting offset XOR i.

Back-pressure rules. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no burst is in progress. A beat is consumed on a cycle where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, the current beat and all of its fields hold steady.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_valid` and `busy` are 0 and `cmd_ready` is 1.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both high. On the next cycle `beat_valid` and `busy` are 1, and the first beat carries the starting column unchanged.
- R3: `bl_code` value 2 selects 2 beats, value 4 selects 4 beats, and any other value selects 8 beats. `bl_code` and `burst_ilv` are sampled only at acceptance; changing them during a burst does not alter that burst.
- R4: For burst length N (N = 2, 4 or 8), the column bits above the low log2(N) bits equal those of the starting column on every beat.
- R5: With `burst_ilv`=0 (sequential), the low offset on beat i is (start offset + i) mod N. For example, N=8 starting at 5 gives 5,6,7,0,1,2,3,4.
- R6: With `burst_ilv`=1 (interleaved), the low offset on beat i is the start offset XOR i. For example, N=8 starting at 5 gives 5,4,7,6,1,0,3,2.
- R7: For N=2, both orders produce the same sequence: 0,1 when column bit 0 is 0, and 1,0 when it is 1.
- R8: `beat_last` is 1 exactly on beat N-1. After that beat is consumed, `beat_valid` and `busy` go to 0 on the next cycle.
- R9: While `beat_valid` is 1 and `beat_ready` is 0, the beat fields (`beat_col`, `beat_last`, `beat_write`) hold, and no beat is skipped.
- R10: `cmd_ready` is 0 while `busy` is 1. A command presented during a burst is ignored: it changes none of the beats of that burst and does not start another burst.
- R11: `beat_write` equals the `cmd_write` value sampled at acceptance, on every beat of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bl_code | input | 4 | Burst length code: 2, 4, otherwise 8 |
| burst_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_write | input | 1 | 1 = write command, 0 = read |
| cmd_col | input | 8 | Starting column address |
| beat_valid | output | 1 | Beat address is present |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_col | output | 8 | Column address of this beat |
| beat_last | output | 1 | Final beat of the burst |
| beat_write | output | 1 | Command kind of this burst |
| busy | output | 1 | Burst in progress |

## Verification
Two events can fall in the same cycle. The first is a new command arriving just as the last beat is consumed, which the bench provokes by keeping `cmd_valid` high for the whole burst. The bench judges it by checking that no burst follows and that `cmd_ready` stayed low until `busy` dropped. The second is a configuration change landing in the cycle right after acceptance. The bench flips `bl_code`, `burst_ilv` and the command fields then, and checks every beat against the order computed from the values sampled at acceptance. Stalls on `beat_ready` are mixed into half of the bursts so that holds and advances both occur at the block's internal wrap points.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int MAX_LG = 3;

  typedef logic [1:0]        lg_t;
  typedef logic [MAX_LG-1:0] beat_t;

  function automatic lg_t bl_to_lg(input logic [3:0] code);
    case (code)
      4'd2:    return 2'd1;
      4'd4:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic beat_t lg_mask(input lg_t lg);
    logic [MAX_LG:0] full;
    full = ({{MAX_LG{1'b0}}, 1'b1} << lg) - 1'b1;
    return full[MAX_LG-1:0];
  endfunction
endpackage

// File: rtl/bcs_cfg_latch.sv
module bcs_cfg_latch
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [3:0]       bl_code,
  input  logic             ilv_in,
  input  logic             wr_in,
  input  logic [COL_W-1:0] col_in,
  output lg_t              lg,
  output logic             ilv,
  output logic             wr,
  output logic [COL_W-1:0] base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lg   <= 2'd3;
      ilv  <= 1'b0;
      wr   <= 1'b0;
      base <= '0;
    end else if (load) begin
      lg   <= bl_to_lg(bl_code);
      ilv  <= ilv_in;
      wr   <= wr_in;
      base <= col_in;
    end
  end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr
  import bcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  adv,
  input  lg_t   lg,
  output logic  active,
  output beat_t beat,
  output logic  last
);
  beat_t final_idx;

  always_comb begin
    final_idx = lg_mask(lg);
    last      = active && (beat == final_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      beat   <= '0;
    end else if (active && adv) begin
      if (last) active <= 1'b0;
      beat <= last ? '0 : beat + 1'b1;
    end
  end

  // R2
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active) |=> (active && beat == '0));

  // R8
  last_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && adv && last) |=> !active);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !adv) |=> (active && $stable(beat)));
endmodule

// File: rtl/bcs_addr_map.sv
module bcs_addr_map
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  lg_t              lg,
  input  logic             ilv,
  input  beat_t            beat,
  output logic [COL_W-1:0] col
);
  beat_t mask, start_off, seq_off, xor_off, sel_off;

  always_comb begin
    mask      = lg_mask(lg);
    start_off = base[MAX_LG-1:0];
    seq_off   = start_off + beat;
    xor_off   = start_off ^ beat;
    sel_off   = ilv ? xor_off : seq_off;
  end

  for (genvar j = 0; j < COL_W; j++) begin : g_bit
    if (j < MAX_LG) begin : g_low
      assign col[j] = mask[j] ? sel_off[j] : base[j];
    end else begin : g_high
      assign col[j] = base[j];
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bl_code,
  input  logic             burst_ilv,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             beat_write,
  output logic             busy
);
  lg_t              cfg_lg;
  logic             cfg_ilv, cfg_wr, active, last, accept;
  logic [COL_W-1:0] cfg_base;
  beat_t            beat;

  assign cmd_ready = !active;
  assign accept    = cmd_valid && !active;

  bcs_cfg_latch #(.COL_W(COL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(accept), .bl_code(bl_code),
    .ilv_in(burst_ilv), .wr_in(cmd_write), .col_in(cmd_col),
    .lg(cfg_lg), .ilv(cfg_ilv), .wr(cfg_wr), .base(cfg_base)
  );

  bcs_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .start(accept), .adv(beat_ready),
    .lg(cfg_lg), .active(active), .beat(beat), .last(last)
  );

  bcs_addr_map #(.COL_W(COL_W)) u_map (
    .base(cfg_base), .lg(cfg_lg), .ilv(cfg_ilv), .beat(beat), .col(beat_col)
  );

  assign beat_valid = active;
  assign beat_last  = last;
  assign beat_write = cfg_wr;
  assign busy       = active;

  // R4
  block_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> $stable(beat_col[COL_W-1:MAX_LG]));

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=>
      (beat_valid && $stable(beat_col) && $stable(beat_last) && $stable(beat_write)));

  // R10
  busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !(beat_ready && beat_last)) |=> busy);

  // R11
  write_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> $stable(beat_write));
endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bl_code = 4'd8;
  logic       burst_ilv = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_write = 1'b0;
  logic [7:0] cmd_col = '0;
  logic       beat_ready = 1'b0;
  logic       cmd_ready, beat_valid, beat_last, beat_write, busy;
  logic [7:0] beat_col;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_seq u_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .bl_code(bl_code), .burst_ilv(burst_ilv),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_col(cmd_col), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_col(beat_col), .beat_last(beat_last), .beat_write(beat_write),
    .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_burst(input logic [3:0] blc, input logic ilv,
                          input logic [7:0] col, input logic wr, input bit stall_on);
    int lg, n, mask, off, exp_off, exp_col, i, cyc;
    lg   = (blc == 4'd2) ? 1 : (blc == 4'd4) ? 2 : 3;
    n    = 1 << lg;
    mask = n - 1;
    off  = col & mask;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R2 ready when idle", cmd_ready, 1);
    cmd_valid = 1'b1; bl_code = blc; burst_ilv = ilv; cmd_col = col; cmd_write = wr;
    beat_ready = 1'b0;
    @(negedge clk);
    // noise presented during the burst: R3 and R10
    cmd_valid = 1'b1; cmd_col = ~col; cmd_write = ~wr;
    bl_code = (blc == 4'd2) ? 4'd8 : 4'd2; burst_ilv = ~ilv;
    i = 0; cyc = 0;
    while (i < n && cyc < 64) begin
      exp_off = ilv ? (off ^ i) : ((off + i) & mask);
      exp_col = (col & ~mask & 8'hFF) | exp_off;
      chk(beat_valid && busy, "R2 valid during burst", beat_valid, 1);
      if (n == 2)
        chk(beat_col == exp_col, "R7 two-beat order", beat_col, exp_col);
      else if (ilv)
        chk(beat_col == exp_col, "R6 interleaved order", beat_col, exp_col);
      else
        chk(beat_col == exp_col, "R5 sequential order", beat_col, exp_col);
      chk((beat_col & ~mask & 8'hFF) == (col & ~mask & 8'hFF), "R4 block bits",
          beat_col, col);
      chk(beat_last == (i == n - 1), "R8 last flag", beat_last, (i == n - 1));
      chk(beat_write == wr, "R11 write kind", beat_write, wr);
      chk(cmd_ready == 1'b0, "R10 ready low while busy", cmd_ready, 0);
      beat_ready = !(stall_on && ((i + cyc) % 3 == 1));
      @(negedge clk);
      if (beat_ready) i++;
      cyc++;
    end
    chk(i == n, "R3 beat count", i, n);
    cmd_valid = 1'b0; beat_ready = 1'b0;
    chk(!beat_valid && !busy, "R8 idle after last", busy, 0);
    @(negedge clk);
    chk(!beat_valid, "R10 no extra burst", beat_valid, 0);
  endtask

  initial begin
    #1;
    chk(!beat_valid && !busy && cmd_ready, "R1 reset state", beat_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!beat_valid && !busy && cmd_ready, "R1 after reset", busy, 0);
    foreach (bl_list[k]) begin
      for (int il = 0; il < 2; il++) begin
        for (int off = 0; off < 8; off++) begin
          logic [7:0] c;
          c = {5'(off * 5 + il * 3 + k * 7), 3'(off)};
          do_burst(bl_list[k], il[0], c, off[1], off[0]);
        end
      end
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  logic [3:0] bl_list [5] = '{4'd2, 4'd4, 4'd8, 4'd5, 4'd0};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule